// File: doc/BRIEF.md
# Match-Compare Timer

This block is a register-mapped timer with several independent up-counters. Each counter has its own set of match comparators, a sticky status bit per comparator, an interrupt-enable mask and a snapshot path for reading the count. Software stops and starts the counters, chooses for each counter whether it counts every clock or only on cycles where a slow tick input is high, and chooses whether the counter wraps freely or restarts after comparator 0 matches. That last mode makes a periodic event source.

Access uses a single-cycle register bus. A write is taken on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. The address splits into a page (upper bits) and a word offset (low three bits). Page 0 holds the shared controls. Page t+1 holds the registers of timer t. Each timer drives one interrupt line, which is high while any enabled comparator status is pending.

The count itself is never read directly. Software writes the timer's snapshot word to request a copy. A busy flag reports when the copy has landed, and the snapshot word then returns the copied value. A typical use is to take a free-running counter as a time base and program match value N-1 on a second counter to get an interrupt N ticks after enabling it.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0, every counter holds 0, every interrupt output is low and no snapshot is busy.
- R2: Word 0 of page 0 holds one enable bit per timer, with bit t for timer t. A write replaces all bits, so writing 0 stops every counter. A disabled counter holds its value. Setting the bit of a stopped timer restarts its count from 0 on that edge.
- R3: Word 1 of page 0 holds a 2-bit clock-select field per timer at bits [2t+1:2t]. Value 0 counts on every clock. Any nonzero value counts only on clocks where `tick_in` is high.
- R4: Word 2 of page 0 holds one mode bit per timer. With mode 1, a counting tick taken while the count equals match value 0 loads 0. With mode 0, the counter increments on every counting tick and wraps from all ones to 0, a period of 2^CNT_W ticks.
- R5: Comparator k sets status bit k on a counting tick taken while the count equals match value k. Match value N-1 therefore gives its event on the N-th tick after enabling.
- R6: Status (offset 3 of a timer page) is cleared by writing 1 to a bit. Bits written 0 are unchanged. Status stays set while the timer is disabled.
- R7: If a status bit is written 1 in the same cycle that its comparator matches, the bit stays set.
- R8: The interrupt for timer t is the OR over comparators of status AND interrupt enable. Interrupt enable is at offset 4, with bit k for comparator k.
- R9: A write to offset 5 of a timer page requests a snapshot. Offset 6 bit 0 reads 1 from the next cycle until the copy is taken, which is two edges after the request edge. Offset 5 then reads the count the counter held after the first edge following the request edge.
- R10: Match values at offsets 0 to 2 read back the low CNT_W bits written. Interrupt enable reads back only its NUM_CMP low bits. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Slow count-enable strobe for timers whose clock select is nonzero |
| bus_wr | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W | Register word address: page in bits [ADDR_W-1:3], offset in bits [2:0] |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| irq | output | NUM_TMR | One interrupt line per timer |

## Verification
The bench builds the block with three timers, three comparators each, and an 8-bit counter. The narrow counter puts the free-running wrap within 256 cycles, so the full period is checked at the first and the second match. The small counter also allows a sweep of every periodic interval from 2 to 13 ticks, with the interrupt checked cycle by cycle over two periods, and a sweep of all three nonzero clock-select codes against a counted number of tick pulses. Expected counts, status words and snapshot values are worked out from the edge numbers in the bench.

// File: rtl/mct_pkg.sv
package mct_pkg;

    localparam int BUS_W = 32;

    // Shared-control words in page 0
    localparam logic [2:0] GW_ENABLE = 3'd0;
    localparam logic [2:0] GW_CLKSEL = 3'd1;
    localparam logic [2:0] GW_MODE   = 3'd2;

    // Per-timer words in page t+1 (offsets 0..2 are match values)
    localparam logic [2:0] TW_STATUS = 3'd3;
    localparam logic [2:0] TW_IRQEN  = 3'd4;
    localparam logic [2:0] TW_SNAP   = 3'd5;
    localparam logic [2:0] TW_BUSY   = 3'd6;

    localparam int CSEL_W = 2;

endpackage

// File: rtl/mct_snapshot.sv
module mct_snapshot #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] snap,
    output logic             busy
);

    typedef struct packed {
        logic             stg1;
        logic             stg2;
        logic             busy;
        logic [CNT_W-1:0] snap;
    } snap_state_t;

    snap_state_t sn_d, sn_q;

    always_comb begin
        sn_d      = sn_q;
        sn_d.stg1 = req;
        sn_d.stg2 = sn_q.stg1;
        if (sn_q.stg2) begin
            sn_d.snap = live;
            sn_d.busy = 1'b0;
        end
        if (req) begin
            sn_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sn_q <= '0;
        end else begin
            sn_q <= sn_d;
        end
    end

    assign snap = sn_q.snap;
    assign busy = sn_q.busy;

    // R9: a request shows busy from the following cycle
    p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> busy);

    // R9: when busy drops, the snapshot holds the count seen just before
    p_snap_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (snap == $past(live)));

endmodule

// File: rtl/mct_channel.sv
module mct_channel
    import mct_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_CMP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             periodic,
    input  logic             sel,
    input  logic [2:0]       off,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0]                  count;
        logic [NUM_CMP-1:0][CNT_W-1:0]     match;
        logic [NUM_CMP-1:0]                stat;
        logic [NUM_CMP-1:0]                ie;
    } chan_state_t;

    chan_state_t ch_d, ch_q;

    logic [NUM_CMP-1:0] hit;
    logic [NUM_CMP-1:0] clr;
    logic               snap_req;
    logic [CNT_W-1:0]   snap_val;
    logic               snap_busy;

    // Comparators: one per match register
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        assign hit[k] = tick && (ch_q.count == ch_q.match[k]);
    end

    assign snap_req = sel && (off == TW_SNAP);

    always_comb begin
        ch_d = ch_q;
        clr  = '0;
        if (sel) begin
            for (int k = 0; k < NUM_CMP; k++) begin
                if (off == 3'(k)) begin
                    ch_d.match[k] = wdata[CNT_W-1:0];
                end
            end
            if (off == TW_IRQEN) begin
                ch_d.ie = wdata[NUM_CMP-1:0];
            end
            if (off == TW_STATUS) begin
                clr = wdata[NUM_CMP-1:0];
            end
        end
        // a match in the same cycle as a clear keeps the bit
        ch_d.stat = (ch_q.stat & ~clr) | hit;

        if (restart) begin
            ch_d.count = '0;
        end else if (tick) begin
            if (periodic && hit[0]) begin
                ch_d.count = '0;
            end else begin
                ch_d.count = ch_q.count + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    mct_snapshot #(
        .CNT_W (CNT_W)
    ) i_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (snap_req),
        .live  (ch_q.count),
        .snap  (snap_val),
        .busy  (snap_busy)
    );

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CMP; k++) begin
            if (off == 3'(k)) begin
                rdata = BUS_W'(ch_q.match[k]);
            end
        end
        case (off)
            TW_STATUS: rdata = BUS_W'(ch_q.stat);
            TW_IRQEN:  rdata = BUS_W'(ch_q.ie);
            TW_SNAP:   rdata = BUS_W'(snap_val);
            TW_BUSY:   rdata = BUS_W'(snap_busy);
            default:   ;
        endcase
    end

    assign irq = |(ch_q.stat & ch_q.ie);

    // R2: without a tick or restart the count does not move
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(ch_q.count));

    // R2: enabling a stopped timer starts from zero
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ch_q.count == '0));

    // R4: periodic mode reloads after comparator 0
    p_periodic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && periodic && (ch_q.count == ch_q.match[0])) |=> (ch_q.count == '0));

    // R4: free-running mode steps by one, wrapping naturally
    p_free_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !periodic) |=> (ch_q.count == $past(ch_q.count) + CNT_W'(1)));

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_chk
        // R6: a pending bit only drops through a clear write
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_q.stat[k] && !(sel && (off == TW_STATUS) && wdata[k])) |=> ch_q.stat[k]);

        // R7: a match always leaves its bit set, clear or not
        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hit[k] |=> ch_q.stat[k]);
    end

endmodule

// File: rtl/match_timer.sv
module match_timer
    import mct_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int NUM_CMP = 3,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_TMR-1:0] irq
);

    localparam int PAGE_W = ADDR_W - 3;

    typedef struct packed {
        logic [NUM_TMR-1:0]             en;
        logic [NUM_TMR-1:0][CSEL_W-1:0] csel;
        logic [NUM_TMR-1:0]             mode;
    } glob_state_t;

    glob_state_t gl_d, gl_q;

    logic [PAGE_W-1:0]  page;
    logic [2:0]         off;
    logic               glob_wr;
    logic [NUM_TMR-1:0] tmr_tick;
    logic [NUM_TMR-1:0] tmr_restart;
    logic [NUM_TMR-1:0] tmr_sel;
    logic [BUS_W-1:0]   tmr_rdata [NUM_TMR];

    assign page    = bus_addr[ADDR_W-1:3];
    assign off     = bus_addr[2:0];
    assign glob_wr = bus_wr && (page == '0);

    always_comb begin
        gl_d = gl_q;
        if (glob_wr) begin
            case (off)
                GW_ENABLE: gl_d.en   = bus_wdata[NUM_TMR-1:0];
                GW_CLKSEL: gl_d.csel = bus_wdata[NUM_TMR*CSEL_W-1:0];
                GW_MODE:   gl_d.mode = bus_wdata[NUM_TMR-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gl_q <= '0;
        end else begin
            gl_q <= gl_d;
        end
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        assign tmr_tick[t]    = gl_q.en[t] && ((gl_q.csel[t] == '0) || tick_in);
        assign tmr_restart[t] = glob_wr && (off == GW_ENABLE) && bus_wdata[t] && !gl_q.en[t];
        assign tmr_sel[t]     = bus_wr && (page == PAGE_W'(t + 1));

        mct_channel #(
            .CNT_W   (CNT_W),
            .NUM_CMP (NUM_CMP)
        ) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tmr_tick[t]),
            .restart  (tmr_restart[t]),
            .periodic (gl_q.mode[t]),
            .sel      (tmr_sel[t]),
            .off      (off),
            .wdata    (bus_wdata),
            .rdata    (tmr_rdata[t]),
            .irq      (irq[t])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (page == '0) begin
            case (off)
                GW_ENABLE: bus_rdata = BUS_W'(gl_q.en);
                GW_CLKSEL: bus_rdata = BUS_W'(gl_q.csel);
                GW_MODE:   bus_rdata = BUS_W'(gl_q.mode);
                default:   ;
            endcase
        end
        for (int t = 0; t < NUM_TMR; t++) begin
            if (page == PAGE_W'(t + 1)) begin
                bus_rdata = tmr_rdata[t];
            end
        end
    end

    // R2: an enable write replaces every enable bit
    p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_wr && (off == GW_ENABLE)) |=> (gl_q.en == $past(bus_wdata[NUM_TMR-1:0])));

    // R3: a stopped timer never counts, whatever the tick input does
    p_no_tick_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gl_q.en == '0) |-> (tmr_tick == '0));

endmodule

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;

    localparam int NT  = 3;
    localparam int NC  = 3;
    localparam int CW  = 8;
    localparam int AW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_in = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NT-1:0] irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    match_timer #(
        .NUM_TMR (NT),
        .NUM_CMP (NC),
        .CNT_W   (CW),
        .ADDR_W  (AW)
    ) i_match_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // one write, taken on exactly one rising edge; returns at the next falling edge
    task automatic wr(input int addr, input int data);
        bus_addr  = AW'(addr);
        bus_wdata = 32'(data);
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] v);
        bus_addr = AW'(addr);
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // snapshot of timer t; checks the busy window and returns the copied count
    task automatic snapshot(input int t, output logic [31:0] v);
        logic [31:0] b;
        wr(8 * (t + 1) + 5, 0);
        rd(8 * (t + 1) + 6, b);
        chk("R9 busy after request", b, 32'd1);
        idle(2);
        rd(8 * (t + 1) + 6, b);
        chk("R9 busy cleared", b, 32'd0);
        rd(8 * (t + 1) + 5, v);
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 32; a++) begin
            rd(a, v);
            chk("R1 register reset", v, 32'd0);
        end
        chk("R1 irq reset", 32'(irq), 32'd0);
        snapshot(0, v);
        chk("R1 count reset", v, 32'd0);

        // R10: readback of match and enable words
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < NC; k++) begin
                wr(8 * (t + 1) + k, 32'h1200 + k * 37 + t * 11 + 5);
            end
            wr(8 * (t + 1) + 4, 32'hFF);
        end
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < NC; k++) begin
                rd(8 * (t + 1) + k, v);
                chk("R10 match readback", v, (k * 37 + t * 11 + 5) & 32'hFF);
            end
            rd(8 * (t + 1) + 4, v);
            chk("R10 irq enable width", v, 32'd7);
            rd(8 * (t + 1) + 7, v);
            chk("R10 unmapped word", v, 32'd0);
            wr(8 * (t + 1) + 4, 0);
        end

        // R9 / R2: timer 1 on the system clock, free-running
        wr(1, 0);
        wr(2, 0);
        wr(0, 2);           // E0: count 0
        snapshot(1, v);     // request at E1, copy taken at E3 of count after E2
        chk("R9 running snapshot", v, 32'd2);
        wr(0, 0);
        wr(0, 2);           // E0
        idle(4);            // E1..E4
        wr(0, 0);           // E5 still counts
        snapshot(1, v);
        chk("R2 stop value", v, 32'd5);
        idle(20);
        snapshot(1, v);
        chk("R2 hold while stopped", v, 32'd5);
        rd(0, v);
        chk("R2 enable word", v, 32'd0);

        // R3: tick-qualified counting for every nonzero select code
        tick_in = 1'b0;
        wr(1, 1 << 2);
        wr(0, 2);
        wr(0, 0);
        snapshot(1, v);
        chk("R2 restart from zero", v, 32'd0);
        for (int s = 1; s < 4; s++) begin
            wr(1, s << 2);
            wr(0, 2);
            idle(3);
            for (int p = 0; p < 3 * s; p++) begin
                tick_in = 1'b1;
                @(posedge clk);
                @(negedge clk);
                tick_in = 1'b0;
                idle(2);
            end
            wr(0, 0);
            snapshot(1, v);
            chk("R3 tick count", v, 32'(3 * s));
        end
        wr(1, 0);

        // R4 / R5 / R8: periodic sweep on timer 0
        wr(2, 1);
        wr(8 + 4, 1);
        for (int m = 1; m <= 12; m++) begin
            wr(0, 0);
            wr(8 + 3, 7);
            wr(8 + 0, m);
            wr(0, 1);                        // E0
            for (int j = 1; j <= m + 1; j++) begin
                @(posedge clk);
                @(negedge clk);
                chk("R5 first event timing", 32'(irq[0]), 32'(j == m + 1));
            end
            wr(8 + 3, 1);                    // E(m+2)
            chk("R6 clear drops irq", 32'(irq[0]), 32'd0);
            for (int j = m + 3; j <= 2 * m + 2; j++) begin
                @(posedge clk);
                @(negedge clk);
                chk("R4 periodic second event", 32'(irq[0]), 32'(j == 2 * m + 2));
            end
        end
        wr(0, 0);
        wr(8 + 4, 0);
        wr(8 + 3, 7);
        wr(2, 0);

        // R5 / R6 / R8: three comparators on timer 2, masked
        wr(24 + 0, 3);
        wr(24 + 1, 5);
        wr(24 + 2, 7);
        wr(24 + 4, 0);
        wr(24 + 3, 7);
        wr(0, 4);                            // E0
        for (int j = 1; j <= 9; j++) begin
            @(posedge clk);
            @(negedge clk);
            rd(24 + 3, v);
            chk("R5 comparator status", v,
                32'((j >= 4) ? 1 : 0) | 32'((j >= 6) ? 2 : 0) | 32'((j >= 8) ? 4 : 0));
            chk("R8 masked irq", 32'(irq[2]), 32'd0);
        end
        wr(0, 0);
        idle(3);
        rd(24 + 3, v);
        chk("R6 sticky while disabled", v, 32'd7);
        wr(24 + 4, 2);
        chk("R8 irq on enable", 32'(irq[2]), 32'd1);
        wr(24 + 3, 5);
        rd(24 + 3, v);
        chk("R6 partial clear", v, 32'd2);
        chk("R8 irq still pending", 32'(irq[2]), 32'd1);
        wr(24 + 3, 2);
        chk("R8 irq after clear", 32'(irq[2]), 32'd0);
        wr(24 + 4, 0);

        // R4: free-running wrap period of 256 on timer 2
        wr(24 + 0, 2);
        wr(0, 4);                            // E0
        idle(3);                             // E3 match
        rd(24 + 3, v);
        chk("R4 first match", v & 1, 32'd1);
        wr(24 + 3, 7);                       // E4
        idle(254);                           // E258
        rd(24 + 3, v);
        chk("R4 no match before wrap", v & 1, 32'd0);
        idle(1);                             // E259
        rd(24 + 3, v);
        chk("R4 match after wrap", v & 1, 32'd1);
        wr(0, 0);

        // R7: clear colliding with a match on timer 0
        wr(8 + 0, 5);
        wr(8 + 3, 7);
        wr(0, 1);                            // E0
        idle(5);                             // E5
        wr(8 + 3, 1);                        // E6 match edge
        rd(8 + 3, v);
        chk("R7 set wins over clear", v & 1, 32'd1);
        wr(8 + 3, 1);
        rd(8 + 3, v);
        chk("R7 later clear", v & 1, 32'd0);
        wr(0, 0);

        finish_run();
    end

endmodule